// File: doc/BRIEF.md
# Status Byte Summary Aggregator

This block forms the top byte of an instrument's status reporting tree. Each cycle it samples the summary bits handed up by the lower status groups: standard event, operation, questionable and device. It also samples a message-available level, which is high while the output queue holds data, and two user summary bits. From these registered samples it builds an 8-bit status byte.

The block then reduces the status byte to two single-bit device summaries. The service request is the OR of the status byte bits that the service request enable register selects. Bit 6 of that register plays no part, because bit 6 of the status byte carries the service request itself. The individual status flag is the OR of all eight status byte bits selected by the parallel poll enable register.

A small register port reads the status byte and reads and writes the two enable registers. The status byte, the service request and the individual status flag follow the registered samples combinationally.

Top module: `stbagg_top`

## Requirements
- R1: The status byte is valid one clock after its inputs are sampled, with this bit layout: bits 1..0 user summaries, bit 2 device, bit 3 questionable, bit 4 message available, bit 5 standard event, bit 7 operation.
- R2: The service request output is the OR, over status byte bits 0..5 and 7, of each bit ANDed with the same bit of the service request enable register.
- R3: Bit 6 of the service request enable register has no effect on the service request output.
- R4: Bit 6 of the status byte always equals the service request output.
- R5: The individual status flag is the OR, over all eight status byte bits including bit 6, of each bit ANDed with the same bit of the parallel poll enable register.
- R6: A synchronous active-high reset clears both enable registers and the sampled inputs, so the status byte, the service request and the individual status flag all read 0 afterwards.
- R7: A write with address 1 loads the service request enable register and a write with address 2 loads the parallel poll enable register. A read of either address returns the stored 8-bit value on the read data output one clock after the read strobe.
- R8: A read of address 0 returns the status byte and a read of address 3 returns 0. Writes to address 0 or 3 change neither enable register nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_sum_i | input | 2 | User summary bits for status byte bits 1..0 |
| dev_sum_i | input | 1 | Device status group summary |
| ques_sum_i | input | 1 | Questionable status group summary |
| msg_avail_i | input | 1 | Output queue holds data |
| evt_sum_i | input | 1 | Standard event group summary |
| oper_sum_i | input | 1 | Operation status group summary |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 status byte, 1 service enable, 2 poll enable, 3 none |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| stb_o | output | 8 | Status byte |
| srq_o | output | 1 | Service request |
| ist_o | output | 1 | Individual status flag |

## Verification
The assertions assume that reset is asserted before the first checked edge and that every summary input is a defined level at each sampling edge. Only then do the message-available copy and the reset-cleared outputs have known values to compare against. The stimulus holds reset for several cycles and then drives every input to a defined value on the falling edge. It sweeps all 128 input patterns against every value of each enable register, so the tool never sees an unknown level at a rising edge.

// File: rtl/stbagg_pkg.sv
package stbagg_pkg;
  localparam int STB_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int USER_W   = 2;
  localparam int POS_DEV  = 2;
  localparam int POS_QUES = 3;
  localparam int POS_MAV  = 4;
  localparam int POS_EVT  = 5;
  localparam int POS_RQS  = 6;
  localparam int POS_OPER = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STB  = 2'd0,
    SEL_SRE  = 2'd1,
    SEL_PPE  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stbagg_capture.sv
module stbagg_capture
  import stbagg_pkg::*;
#(
  parameter int W  = STB_W,
  parameter int UW = USER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [UW-1:0] user_sum_i,
  input  logic          dev_sum_i,
  input  logic          ques_sum_i,
  input  logic          msg_avail_i,
  input  logic          evt_sum_i,
  input  logic          oper_sum_i,
  output logic [W-1:0]  raw_q
);
  logic [W-1:0] raw_d;

  always_comb begin
    raw_d           = '0;
    raw_d[UW-1:0]   = user_sum_i;
    raw_d[POS_DEV]  = dev_sum_i;
    raw_d[POS_QUES] = ques_sum_i;
    raw_d[POS_MAV]  = msg_avail_i;
    raw_d[POS_EVT]  = evt_sum_i;
    raw_d[POS_OPER] = oper_sum_i;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_d;
  end
endmodule

// File: rtl/stbagg_enables.sv
module stbagg_enables
  import stbagg_pkg::*;
#(
  parameter int W  = STB_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  sre_q,
  output logic [W-1:0]  ppe_q
);
  logic hit_sre;
  logic hit_ppe;

  assign hit_sre = wr_i && (addr_i == AW'(SEL_SRE));
  assign hit_ppe = wr_i && (addr_i == AW'(SEL_PPE));

  always_ff @(posedge clk) begin
    if (rst) begin
      sre_q <= '0;
      ppe_q <= '0;
    end else begin
      if (hit_sre) sre_q <= wdata_i;
      if (hit_ppe) ppe_q <= wdata_i;
    end
  end
endmodule

// File: rtl/stbagg_combine.sv
module stbagg_combine
  import stbagg_pkg::*;
#(
  parameter int W    = STB_W,
  parameter int RQSB = POS_RQS
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] sre_i,
  input  logic [W-1:0] ppe_i,
  output logic [W-1:0] stb_o,
  output logic         rss_o,
  output logic         ist_o
);
  logic [W-1:0] srq_terms;
  logic [W-1:0] ist_terms;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      if (g == RQSB) begin : g_rqs
        assign srq_terms[g] = 1'b0;
        assign stb_o[g]     = rss_o;
      end else begin : g_sum
        assign srq_terms[g] = raw_i[g] & sre_i[g];
        assign stb_o[g]     = raw_i[g];
      end
      assign ist_terms[g] = stb_o[g] & ppe_i[g];
    end
  endgenerate

  assign rss_o = |srq_terms;
  assign ist_o = |ist_terms;
endmodule

// File: rtl/stbagg_top.sv
module stbagg_top
  import stbagg_pkg::*;
#(
  parameter int W  = STB_W,
  parameter int AW = ADDR_W,
  parameter int UW = USER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [UW-1:0] user_sum_i,
  input  logic          dev_sum_i,
  input  logic          ques_sum_i,
  input  logic          msg_avail_i,
  input  logic          evt_sum_i,
  input  logic          oper_sum_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic [W-1:0]  stb_o,
  output logic          srq_o,
  output logic          ist_o
);
  logic [W-1:0] raw_q;
  logic [W-1:0] sre_q;
  logic [W-1:0] ppe_q;
  logic [W-1:0] rd_mux;

  stbagg_capture #(.W(W), .UW(UW)) u_cap (
    .clk(clk), .rst(rst),
    .user_sum_i(user_sum_i), .dev_sum_i(dev_sum_i), .ques_sum_i(ques_sum_i),
    .msg_avail_i(msg_avail_i), .evt_sum_i(evt_sum_i), .oper_sum_i(oper_sum_i),
    .raw_q(raw_q)
  );

  stbagg_enables #(.W(W), .AW(AW)) u_en (
    .clk(clk), .rst(rst),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .sre_q(sre_q), .ppe_q(ppe_q)
  );

  stbagg_combine #(.W(W), .RQSB(POS_RQS)) u_comb (
    .raw_i(raw_q), .sre_i(sre_q), .ppe_i(ppe_q),
    .stb_o(stb_o), .rss_o(srq_o), .ist_o(ist_o)
  );

  always_comb begin
    case (reg_addr_i)
      AW'(SEL_STB): rd_mux = stb_o;
      AW'(SEL_SRE): rd_mux = sre_q;
      AW'(SEL_PPE): rd_mux = ppe_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/stbagg_chk.sv
module stbagg_chk
  import stbagg_pkg::*;
#(
  parameter int W = STB_W
) (
  input logic         clk,
  input logic         rst,
  input logic         msg_avail_i,
  input logic         oper_sum_i,
  input logic [W-1:0] stb_o,
  input logic         srq_o,
  input logic         ist_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!srq_o && !ist_o && stb_o == '0)); // R6

  AST_MAV_POSITION: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (stb_o[POS_MAV] == $past(msg_avail_i))); // R1

  AST_OPER_POSITION: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (stb_o[POS_OPER] == $past(oper_sum_i))); // R1

  AST_SRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    srq_o |-> ((stb_o & ~(W'(1) << POS_RQS)) != '0)); // R2

  AST_SRQ_IN_STB: assert property (@(posedge clk) disable iff (rst)
    stb_o[POS_RQS] == srq_o); // R4

  AST_IST_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ist_o |-> (stb_o != '0)); // R5
endmodule

bind stbagg_top stbagg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .msg_avail_i(msg_avail_i), .oper_sum_i(oper_sum_i),
  .stb_o(stb_o), .srq_o(srq_o), .ist_o(ist_o)
);

// File: tb/stbagg_top_tb.sv
module stbagg_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] user_sum_i;
  logic       dev_sum_i, ques_sum_i, msg_avail_i, evt_sum_i, oper_sum_i;
  logic       reg_wr_i, reg_rd_i;
  logic [1:0] reg_addr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o, stb_o;
  logic       srq_o, ist_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  stbagg_top u_dut (
    .clk(clk), .rst(rst), .user_sum_i(user_sum_i), .dev_sum_i(dev_sum_i),
    .ques_sum_i(ques_sum_i), .msg_avail_i(msg_avail_i), .evt_sum_i(evt_sum_i),
    .oper_sum_i(oper_sum_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .stb_o(stb_o), .srq_o(srq_o), .ist_o(ist_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // pattern bits: [1:0] user, 2 dev, 3 ques, 4 mav, 5 evt, 6 oper
  task automatic drive(input logic [6:0] p);
    user_sum_i = p[1:0]; dev_sum_i = p[2]; ques_sum_i = p[3];
    msg_avail_i = p[4]; evt_sum_i = p[5]; oper_sum_i = p[6];
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    step();
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  function automatic logic [7:0] base_of(input logic [6:0] p);
    return {p[6], 1'b0, p[5:0]};
  endfunction

  function automatic logic rss_of(input logic [6:0] p, input logic [7:0] sre);
    return |(base_of(p) & sre & 8'hBF);
  endfunction

  function automatic logic [7:0] stb_of(input logic [6:0] p, input logic [7:0] sre);
    logic [7:0] s;
    s = base_of(p);
    s[6] = rss_of(p, sre);
    return s;
  endfunction

  initial begin
    logic [7:0] rv;
    rst = 1'b1; reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    drive(7'h7F);
    repeat (3) @(negedge clk);
    chk("R6 stb after reset", stb_o, 8'h00);
    chk("R6 srq/ist after reset", {6'd0, srq_o, ist_o}, 8'h00);
    rst = 1'b0;
    drive(7'h00);
    rd(2'd1, rv); chk("R6 service enable reset", rv, 8'h00);
    rd(2'd2, rv); chk("R6 poll enable reset", rv, 8'h00);

    // R1 R2 R3 R4: every service enable value against every input pattern
    for (int s = 0; s < 256; s++) begin
      wr(2'd1, 8'(s));
      for (int p = 0; p < 128; p++) begin
        drive(7'(p));
        step();
        chk("R1 R4 status byte", stb_o, stb_of(7'(p), 8'(s)));
        chk("R2 R3 service request", {7'd0, srq_o}, {7'd0, rss_of(7'(p), 8'(s))});
        chk("R5 ist with poll enable zero", {7'd0, ist_o}, 8'h00);
      end
    end

    // R3 explicitly: only bit 6 enabled, all sources high
    wr(2'd1, 8'h40); drive(7'h7F); step();
    chk("R3 enable bit6 ignored", {7'd0, srq_o}, 8'h00);

    // R5: every poll enable value, two service enable settings
    for (int k = 0; k < 2; k++) begin
      logic [7:0] sv;
      sv = (k == 0) ? 8'h10 : 8'hFF;
      wr(2'd1, sv);
      for (int e = 0; e < 256; e++) begin
        wr(2'd2, 8'(e));
        for (int p = 0; p < 128; p++) begin
          drive(7'(p));
          step();
          chk("R5 individual status", {7'd0, ist_o},
              {7'd0, |(stb_of(7'(p), sv) & 8'(e))});
        end
      end
    end

    // R7 readback
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd(2'd1, rv); chk("R7 service enable readback", rv, 8'hA5);
    rd(2'd2, rv); chk("R7 poll enable readback", rv, 8'h3C);

    // R8 status byte read, null address, ignored writes
    drive(7'h55); step();
    rd(2'd0, rv); chk("R8 status byte read", rv, stb_of(7'h55, 8'hA5));
    rd(2'd3, rv); chk("R8 null address read", rv, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd3, 8'hFF);
    chk("R8 stb unchanged by writes", stb_o, stb_of(7'h55, 8'hA5));
    rd(2'd1, rv); chk("R8 service enable untouched", rv, 8'hA5);
    rd(2'd2, rv); chk("R8 poll enable untouched", rv, 8'h3C);

    // R6 reset again clears enables
    rst = 1'b1; step(); rst = 1'b0;
    rd(2'd1, rv); chk("R6 service enable cleared", rv, 8'h00);
    rd(2'd2, rv); chk("R6 poll enable cleared", rv, 8'h00);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule